// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. It has separate, free-running write and read clocks. It stores words in an inferred dual-port register array of 2^AW entries. The default is AW = 11, which gives 2048 words. Deeper buffers, of 16K or 32K words, come from raising AW. A small AW is used for simulation. A write and a read may occur in the same cycle of their own clocks.

Both pointers cross between the clock domains as Gray code through two-flop synchronizers. The read domain derives the empty, output-ready and almost-empty status. The write domain derives the full, input-ready, half-full and almost-full status.

The almost-empty and almost-full thresholds are programmable and are loaded through the data port. The load is serial, one bit per write clock, or parallel, one whole word per write. The loading method, the read timing mode and the preset threshold pair are all captured while master reset is held. A partial reset empties the buffer but keeps the thresholds and the modes. A retransmit request rewinds the read side to the first stored location, so the stored sequence can be read again.

Top module: `fifo_dual_clk`

## Requirements
- R1: While master reset (`mrstN` low) is held for at least two clocks of each domain and then released, in standard mode the block shows `rdStatus`=1 (empty), `wrStatus`=0, `halfFull`=0, `almostEmpty`=1 and `almostFull`=0.
- R2: Words accepted on `dIn` (`wEn`=1, `ldEn`=0, not full) leave on `dOut` in the order they were written, for any ratio between the two clock periods, with writing and reading running concurrently.
- R3: In standard mode `wrStatus`=1 exactly when 2^AW words are stored. A write attempted while full stores nothing and leaves the stored sequence unchanged.
- R4: In standard mode `rdStatus`=1 exactly when no word is stored. A read (`rEn`=1) issued while empty leaves `dOut` and the read position unchanged. A read while not empty places the next word on `dOut` at that read-clock edge.
- R5: `halfFull`=1 exactly when the stored word count exceeds 2^AW/2.
- R6: `almostEmpty`=1 when the count is at most the empty threshold. `almostFull`=1 when the count is at least 2^AW minus the full threshold. Both thresholds are AW bits wide.
- R7: Master reset loads both thresholds with `OFF_DEF0` when `cfgPreset`=0, or with `OFF_DEF1` when `cfgPreset`=1. It also captures `cfgFwft` (1 selects fall-through timing) and `cfgSerial` (1 selects serial threshold loading).
- R8: In parallel loading mode, a write with `ldEn`=1 stores nothing in the buffer. Its `dIn[AW-1:0]` goes alternately to the empty threshold (the first load after any reset) and then to the full threshold.
- R9: In serial loading mode, each write clock with `ldEn`=1 and `serEn`=1 shifts `dIn[0]` into a 2·AW-bit chain. The first bit shifted lands in the empty threshold's bit 0 after 2·AW shifts. Bits AW to 2·AW−1 of the chain form the full threshold, least significant bit first.
- R10: Partial reset (`prstN` low) empties the buffer and leaves the thresholds and the captured modes unchanged.
- R11: In fall-through mode, `rdStatus`=1 means `dOut` holds an unread word. The oldest word appears there without any read request, and `rEn` consumes it. `wrStatus`=1 means there is room for a write.
- R12: A one-clock `rtReq` pulse, given in standard mode after fewer than 2^AW writes since the last reset, makes the words written since that reset readable again from the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low |
| prstN | input | 1 | Partial reset, active low |
| cfgPreset | input | 1 | Preset threshold pair select, captured at master reset |
| cfgFwft | input | 1 | Fall-through timing select, captured at master reset |
| cfgSerial | input | 1 | Serial threshold loading select, captured at master reset |
| wEn | input | 1 | Write enable |
| ldEn | input | 1 | Threshold load select |
| serEn | input | 1 | Serial shift enable |
| dIn | input | DW | Write data and threshold data |
| rEn | input | 1 | Read enable |
| rtReq | input | 1 | Retransmit request, read domain |
| dOut | output | DW | Read data |
| rdStatus | output | 1 | Empty (standard) or output-ready (fall-through) |
| wrStatus | output | 1 | Full (standard) or input-ready (fall-through) |
| halfFull | output | 1 | More than half the depth is occupied |
| almostEmpty | output | 1 | Level at or below the empty threshold |
| almostFull | output | 1 | Level at or above depth minus the full threshold |

## Verification
The assertions check several rules at every clock edge. The write position is frozen while full, and the half-full flag is implied by full. In standard mode, `dOut` holds still while empty and the read position advances by one on each accepted read. An unread fall-through word stays presented until it is consumed.

Other properties can only be shown by the bench's scenarios: threshold loading by either method, the preset choice, survival of the thresholds across partial reset, retransmit replay, and data ordering under varied clock ratios.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic memWr;   // store dIn at the write address (write clock)
    logic rdLoad;  // load the output register from the read address (read clock)
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_dc_dpath.sv
module fifo_dc_dpath
  import fifo_dc_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          rstN,
  input  fifoStrobes_t  st,
  input  logic [AW-1:0] wAddr,
  input  logic [AW-1:0] rAddr,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] dOut
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wClk) begin
    if (st.memWr) store[wAddr] <= dIn;
  end

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN)          dOut <= '0;
    else if (st.rdLoad) dOut <= store[rAddr];
  end
endmodule

// File: rtl/fifo_dc_ctrl.sv
module fifo_dc_ctrl
  import fifo_dc_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 9,
  parameter int OFF_DEF0 = 7,
  parameter int OFF_DEF1 = 63
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          rstN,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          cfgPreset,
  input  logic          cfgFwft,
  input  logic          cfgSerial,
  input  logic          wEn,
  input  logic          ldEn,
  input  logic          serEn,
  input  logic [DW-1:0] dIn,
  input  logic          rEn,
  input  logic          rtReq,
  output fifoStrobes_t  st,
  output logic [AW-1:0] wAddr,
  output logic [AW-1:0] rAddr,
  output logic          fwftMode,
  output logic          fullW,
  output logic          rdStatus,
  output logic          wrStatus,
  output logic          halfFull,
  output logic          almostEmpty,
  output logic          almostFull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wPtr, wGrayQ, rGs1, rGs2, rPtrW, wLevel, wPtrNext;
  logic [AW-1:0] aeOff, afOff;
  logic          serMode, ldSel;
  logic [2*AW-1:0] offChain;

  assign rPtrW    = fromGray(rGs2);
  assign wLevel   = wPtr - rPtrW;
  assign fullW    = (wLevel == DEPTH_P);
  assign st.memWr = wEn && !ldEn && !fullW;
  assign wPtrNext = wPtr + 1'b1;
  assign wAddr    = wPtr[AW-1:0];
  assign offChain = {dIn[0], afOff, aeOff[AW-1:1]};

  always_ff @(posedge wClk or negedge rstN) begin
    if (!rstN) begin
      wPtr   <= '0;
      wGrayQ <= '0;
      rGs1   <= '0;
      rGs2   <= '0;
    end else begin
      rGs1 <= rGrayQ;
      rGs2 <= rGs1;
      if (st.memWr) begin
        wPtr   <= wPtrNext;
        wGrayQ <= toGray(wPtrNext);
      end
    end
  end

  // Configuration: captured while master reset is low, kept over partial reset.
  always_ff @(posedge wClk) begin
    if (!mrstN) begin
      fwftMode <= cfgFwft;
      serMode  <= cfgSerial;
      aeOff    <= cfgPreset ? AW'(OFF_DEF1) : AW'(OFF_DEF0);
      afOff    <= cfgPreset ? AW'(OFF_DEF1) : AW'(OFF_DEF0);
      ldSel    <= 1'b0;
    end else if (!prstN) begin
      ldSel <= 1'b0;
    end else if (ldEn) begin
      if (serMode && serEn) begin
        {afOff, aeOff} <= offChain;
      end else if (!serMode && wEn) begin
        if (ldSel) afOff <= AW'(dIn);
        else       aeOff <= AW'(dIn);
        ldSel <= !ldSel;
      end
    end
  end

  assign halfFull   = (wLevel > HALF_P);
  assign almostFull = (wLevel >= (DEPTH_P - {1'b0, afOff}));
  assign wrStatus   = fwftMode ? !fullW : fullW;

  // ---------------- read domain ----------------
  logic [PW-1:0] rPtr, rGrayQ, wGs1, wGs2, wPtrR, rLevel, rPtrNext;
  logic          memEmpty, outValid;

  assign wPtrR     = fromGray(wGs2);
  assign memEmpty  = (wPtrR == rPtr);
  assign rPtrNext  = rPtr + 1'b1;
  assign rAddr     = rPtr[AW-1:0];
  assign st.rdLoad = !rtReq && !memEmpty && (fwftMode ? (!outValid || rEn) : rEn);

  always_ff @(posedge rClk or negedge rstN) begin
    if (!rstN) begin
      rPtr     <= '0;
      rGrayQ   <= '0;
      wGs1     <= '0;
      wGs2     <= '0;
      outValid <= 1'b0;
    end else begin
      wGs1 <= wGrayQ;
      wGs2 <= wGs1;
      if (rtReq) begin
        rPtr     <= '0;
        rGrayQ   <= '0;
        outValid <= 1'b0;
      end else begin
        if (st.rdLoad) begin
          rPtr   <= rPtrNext;
          rGrayQ <= toGray(rPtrNext);
        end
        if (fwftMode) outValid <= st.rdLoad || (outValid && !rEn);
      end
    end
  end

  assign rLevel      = (wPtrR - rPtr) + PW'(outValid);
  assign almostEmpty = (rLevel <= {1'b0, aeOff});
  assign rdStatus    = fwftMode ? outValid : memEmpty;
endmodule

// File: rtl/fifo_dual_clk.sv
module fifo_dual_clk
  import fifo_dc_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 9,
  parameter int OFF_DEF0 = 7,
  parameter int OFF_DEF1 = 63
) (
  input  logic          wClk,
  input  logic          rClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          cfgPreset,
  input  logic          cfgFwft,
  input  logic          cfgSerial,
  input  logic          wEn,
  input  logic          ldEn,
  input  logic          serEn,
  input  logic [DW-1:0] dIn,
  input  logic          rEn,
  input  logic          rtReq,
  output logic [DW-1:0] dOut,
  output logic          rdStatus,
  output logic          wrStatus,
  output logic          halfFull,
  output logic          almostEmpty,
  output logic          almostFull
);
  fifoStrobes_t  st;
  logic [AW-1:0] wAddr, rAddr;
  logic          fwftMode, fullW;
  logic          rstN;

  assign rstN = mrstN & prstN;

  fifo_dc_ctrl #(.AW(AW), .DW(DW), .OFF_DEF0(OFF_DEF0), .OFF_DEF1(OFF_DEF1)) u_ctrl (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .mrstN(mrstN), .prstN(prstN),
    .cfgPreset(cfgPreset), .cfgFwft(cfgFwft), .cfgSerial(cfgSerial),
    .wEn(wEn), .ldEn(ldEn), .serEn(serEn), .dIn(dIn), .rEn(rEn), .rtReq(rtReq),
    .st(st), .wAddr(wAddr), .rAddr(rAddr), .fwftMode(fwftMode), .fullW(fullW),
    .rdStatus(rdStatus), .wrStatus(wrStatus), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  fifo_dc_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .st(st),
    .wAddr(wAddr), .rAddr(rAddr), .dIn(dIn), .dOut(dOut)
  );
endmodule

// File: rtl/fifo_dual_clk_chk.sv
module fifo_dual_clk_chk #(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input logic          wClk,
  input logic          rClk,
  input logic          rstN,
  input logic          rEn,
  input logic          rtReq,
  input logic          fwftMode,
  input logic          fullW,
  input logic          rdStatus,
  input logic          halfFull,
  input logic [AW-1:0] wAddr,
  input logic [AW-1:0] rAddr,
  input logic [DW-1:0] dOut
);
  // R3
  no_overflow_chk: assert property (@(posedge wClk) disable iff (!rstN)
    fullW |=> (wAddr == $past(wAddr)));

  // R5
  full_is_half_chk: assert property (@(posedge wClk) disable iff (!rstN)
    fullW |-> halfFull);

  // R4
  no_underflow_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (!fwftMode && rdStatus && !rtReq) |=> $stable(dOut));

  // R4
  read_step_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (!fwftMode && rEn && !rdStatus && !rtReq) |=> (rAddr == AW'($past(rAddr) + 1'b1)));

  // R11
  fwft_hold_chk: assert property (@(posedge rClk) disable iff (!rstN)
    (fwftMode && rdStatus && !rEn && !rtReq) |=> (rdStatus && $stable(dOut)));
endmodule

bind fifo_dual_clk fifo_dual_clk_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/fifo_dual_clk_bench.sv
`timescale 1ns/1ps
module fifo_dual_clk_bench;
  localparam int AW = 4;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int D0 = 2;
  localparam int D1 = 5;

  logic wClk = 1'b0, rClk = 1'b0;
  logic mrstN = 1'b0, prstN = 1'b1;
  logic cfgPreset = 1'b0, cfgFwft = 1'b0, cfgSerial = 1'b0;
  logic wEn = 1'b0, ldEn = 1'b0, serEn = 1'b0, rEn = 1'b0, rtReq = 1'b0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic rdStatus, wrStatus, halfFull, almostEmpty, almostFull;

  int checks = 0, failures = 0;
  realtime rHalf = 3.1;
  logic [DW-1:0] q[$];

  fifo_dual_clk #(.AW(AW), .DW(DW), .OFF_DEF0(D0), .OFF_DEF1(D1)) u_fifo_dual_clk (
    .wClk(wClk), .rClk(rClk), .mrstN(mrstN), .prstN(prstN),
    .cfgPreset(cfgPreset), .cfgFwft(cfgFwft), .cfgSerial(cfgSerial),
    .wEn(wEn), .ldEn(ldEn), .serEn(serEn), .dIn(dIn), .rEn(rEn), .rtReq(rtReq),
    .dOut(dOut), .rdStatus(rdStatus), .wrStatus(wrStatus), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  always #2 wClk = ~wClk;
  initial begin
    #0.7;
    forever #(rHalf) rClk = ~rClk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    #160;
  endtask

  task automatic doMrst(input logic pre, input logic fw, input logic ser);
    @(negedge wClk);
    mrstN = 1'b0; cfgPreset = pre; cfgFwft = fw; cfgSerial = ser;
    wEn = 0; ldEn = 0; serEn = 0; rEn = 0; rtReq = 0;
    repeat (4) @(posedge wClk);
    repeat (3) @(posedge rClk);
    @(negedge wClk) mrstN = 1'b1;
    settle();
  endtask

  task automatic doPrst();
    @(negedge wClk) prstN = 1'b0;
    repeat (3) @(posedge wClk);
    repeat (3) @(posedge rClk);
    @(negedge wClk) prstN = 1'b1;
    settle();
  endtask

  task automatic writeWord(input logic [DW-1:0] v);
    @(negedge wClk); wEn = 1'b1; dIn = v;
    @(negedge wClk); wEn = 1'b0;
  endtask

  task automatic readStd(output logic [DW-1:0] v);
    @(negedge rClk); rEn = 1'b1;
    @(negedge rClk); rEn = 1'b0; v = dOut;
  endtask

  // Fill from empty, one word at a time, checking every level; then drain.
  task automatic sweep(input int ae, input int af);
    logic [DW-1:0] v;
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) writeWord(DW'(n + 32));
      settle();
      check("R3 full", int'(wrStatus), int'(n == DEPTH));
      check("R4 empty", int'(rdStatus), int'(n == 0));
      check("R5 halfFull", int'(halfFull), int'(n > DEPTH / 2));
      check("R6 almostEmpty", int'(almostEmpty), int'(n <= ae));
      check("R6 almostFull", int'(almostFull), int'(n >= DEPTH - af));
    end
    writeWord(9'h1FF); // R3: write while full must be dropped
    settle();
    for (int n = 1; n <= DEPTH; n++) begin
      readStd(v);
      check("R2 order", int'(v), n + 32);
    end
    settle();
    check("R3 nothing extra stored", int'(rdStatus), 1);
    readStd(v); // R4: read while empty
    check("R4 dOut held", int'(v), DEPTH + 32);
  endtask

  task automatic traffic(input int count, input logic fw);
    int sent = 0, got = 0;
    q.delete();
    fork
      begin
        while (sent < count) begin
          @(negedge wClk);
          wEn = 1'b0;
          if ((fw ? wrStatus : !wrStatus) && ($urandom % 3 != 0)) begin
            wEn = 1'b1; dIn = DW'($urandom); q.push_back(dIn); sent++;
          end
        end
        @(negedge wClk) wEn = 1'b0;
      end
      begin
        logic pend = 1'b0;
        while (got < count) begin
          @(negedge rClk);
          if (!fw && pend) begin
            if (q.size() == 0) check("R2 queue underrun", 1, 0);
            else check("R2 ordered data", int'(dOut), int'(q.pop_front()));
            got++;
          end
          rEn = 1'b0; pend = 1'b0;
          if (got < count && ($urandom % 2 == 1)) begin
            if (!fw && !rdStatus) begin
              rEn = 1'b1; pend = 1'b1;
            end else if (fw && rdStatus) begin
              if (q.size() == 0) check("R11 queue underrun", 1, 0);
              else check("R11 ordered data", int'(dOut), int'(q.pop_front()));
              got++; rEn = 1'b1;
            end
          end
        end
        @(negedge rClk) rEn = 1'b0;
      end
    join
  endtask

  initial begin
    logic [DW-1:0] v;
    // R1, R7 preset 0
    doMrst(1'b0, 1'b0, 1'b0);
    check("R1 rdStatus", int'(rdStatus), 1);
    check("R1 wrStatus", int'(wrStatus), 0);
    check("R1 halfFull", int'(halfFull), 0);
    check("R1 almostEmpty", int'(almostEmpty), 1);
    check("R1 almostFull", int'(almostFull), 0);
    sweep(D0, D0);
    // R7 preset 1
    doMrst(1'b1, 1'b0, 1'b0);
    sweep(D1, D1);
    // R8 parallel load: empty threshold 3, full threshold 6
    doMrst(1'b0, 1'b0, 1'b0);
    @(negedge wClk); ldEn = 1'b1; wEn = 1'b1; dIn = 9'd3;
    @(negedge wClk); dIn = 9'd6;
    @(negedge wClk); ldEn = 1'b0; wEn = 1'b0;
    settle();
    check("R8 load stores no data", int'(rdStatus), 1);
    sweep(3, 6);
    // R10 partial reset empties, keeps thresholds
    writeWord(9'd1); writeWord(9'd2); writeWord(9'd3);
    settle();
    check("R10 filled before reset", int'(rdStatus), 0);
    doPrst();
    check("R10 emptied", int'(rdStatus), 1);
    sweep(3, 6);
    // R9 serial load: empty threshold 4, full threshold 7
    doMrst(1'b0, 1'b0, 1'b1);
    for (int b = 0; b < 2 * AW; b++) begin
      @(negedge wClk); ldEn = 1'b1; serEn = 1'b1;
      dIn = DW'(b < AW ? ((4 >> b) & 1) : ((7 >> (b - AW)) & 1));
    end
    @(negedge wClk); ldEn = 1'b0; serEn = 1'b0;
    sweep(4, 7);
    // R12 retransmit
    doMrst(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) writeWord(DW'(64 + i));
    settle();
    for (int i = 0; i < 5; i++) begin readStd(v); check("R12 first pass", int'(v), 64 + i); end
    @(negedge rClk) rtReq = 1'b1;
    @(negedge rClk) rtReq = 1'b0;
    settle();
    check("R12 data readable again", int'(rdStatus), 0);
    for (int i = 0; i < 5; i++) begin readStd(v); check("R12 replay", int'(v), 64 + i); end
    // R11 fall-through basics
    doMrst(1'b0, 1'b1, 1'b0);
    check("R11 not ready at reset", int'(rdStatus), 0);
    check("R11 input ready at reset", int'(wrStatus), 1);
    writeWord(9'h0A5);
    settle();
    check("R11 word presented", int'(rdStatus), 1);
    check("R11 word value", int'(dOut), 9'h0A5);
    @(negedge rClk) rEn = 1'b1;
    @(negedge rClk) rEn = 1'b0;
    settle();
    check("R11 consumed", int'(rdStatus), 0);
    for (int i = 0; i < DEPTH + 1; i++) writeWord(DW'(i));
    settle();
    check("R11 no room when full", int'(wrStatus), 0);
    // R2 / R11 concurrent traffic under several clock ratios
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 4; k++) begin
        rHalf = (k == 0) ? 1.3 : (k == 1) ? 3.1 : (k == 2) ? 5.3 : 7.7;
        doMrst(1'b0, m[0], 1'b0);
        traffic(150, m[0]);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #700000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule